// File: doc/BRIEF.md
# Message-Signaled Interrupt Source Bank

This block holds a bank of shared interrupt sources that are raised by single-cycle message strobes. Each source has a control word and a routing word. The control word holds the mask, the priority, the vector and a read-only activity flag. The routing word says where the request goes. Software reaches both words through a small register port. That port reads back one cycle after the request and writes in the cycle it is presented.

A strobe latches a pending bit for its source. An unmasked pending source with a non-zero priority is eligible. Each eligible source drives exactly one target, chosen from its routing word: the external request pin, the critical request pin, or one processor request line. A read of the acknowledge location returns the vector of the best eligible source and moves that source from pending to in-service. An end-of-interrupt write retires the most recently acknowledged source.

In-service sources may nest, because each acknowledge takes only a source of strictly higher priority than the current one. The current in-service priority is therefore the highest priority among in-service sources.

Top module: `msi_src_bank`

## Requirements
- R1: After reset every source reads masked, with priority, vector, routing, pending and in-service all zero. Every control word therefore reads 0x8000_0000, every routing word reads 0, and cpuIrq, extIrq and critIrq are low.
- R2: Address map and timing.
  - The control word of source n sits at byte address 0x20*n and its routing word at 0x20*n+0x10.
  - In the control word, bit 31 is the mask, bit 30 is activity, bits 19:16 are the priority and bits 15:0 are the vector. Every other bit reads 0.
  - Read data appears on rdData in the cycle after rdEn.
- R3: A strobe on srcSignal[n] sets the pending bit of source n whether or not it is masked. A masked source raises no request and cannot be acknowledged. Clearing the mask while the source is pending makes it request in the next cycle.
- R4: A source whose priority is 0 raises no request and is never acknowledged, even when it is pending and unmasked.
- R5: The activity bit reads 1 exactly when the source is pending or in service. Writes to it have no effect.
- R6: While a source's activity bit is 1, writes to its control word leave the priority unchanged but still update the mask and the vector.
- R7: Routing word layout and target selection.
  - Bit 31 sends the source to extIrq. Bit 30 sends it to critIrq. Bits NUM_CPU-1:0 select processors. All other bits read 0.
  - The external bit takes precedence over the critical bit, and both take precedence over the processor bits.
  - When several processor bits are set, only the lowest-numbered one is used.
- R8: Acknowledge read at address 0x100.
  - The read considers eligible sources whose priority is above the current in-service priority. It returns the 16-bit vector, zero-extended, of the one with the highest priority; equal priorities go to the lowest index.
  - That source leaves pending and enters in-service.
  - With no such source the read returns 0x0000_FFFF and changes nothing.
- R9: A write to address 0x110 clears the in-service bit of the most recently acknowledged source, which is the in-service source with the highest priority. With nothing in service it has no effect.
- R10: Request outputs.
  - cpuIrq[k] is high exactly when an eligible source routed to processor k has a priority above the current in-service priority, which is 0 when nothing is in service.
  - extIrq and critIrq are high whenever an eligible source is routed to them, whatever is in service.
- R11: Reads of any other address return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| srcSignal | input | NUM_SRC | One-cycle message strobes, one per source |
| rdEn | input | 1 | Register read request |
| wrEn | input | 1 | Register write request |
| addr | input | ADDR_W | Byte address of the register access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid the cycle after rdEn |
| cpuIrq | output | NUM_CPU | Request line per processor |
| extIrq | output | 1 | External pin request |
| critIrq | output | 1 | Critical pin request |

## Verification
The bench goes after these corner cases:
- **Priority change during activity.** A source changes priority while it is pending. A design that let that write through would return the wrong acknowledge vector or reorder later selections.
- **Nested acknowledges and retirement order.** Two sources are acknowledged in nested order and then retired one at a time. A design that retired the wrong in-service source would raise or drop a processor line at the wrong moment.
- **Equal priority.** Equal-priority sources are acknowledged in turn. A tie broken toward the higher index would return the other vector.
- **Masking, zero priority and spurious reads.** Masked and zero-priority pending sources are probed, together with acknowledges that must come back spurious. A design that leaked any of them would raise a line or return a real vector.
- **Routing and addressing.** Routing words with several target bits set, and unmapped addresses, check the precedence order and the decode.

// File: rtl/msi_src_pkg.sv
package msi_src_pkg;

  localparam int DATA_W     = 32;
  localparam int SRC_IDX_W  = 5;   // supports up to 32 sources
  localparam int MASK_BIT   = 31;  // control word
  localparam int ACT_BIT    = 30;  // control word
  localparam int PRIO_LSB   = 16;  // control word
  localparam int EXT_BIT    = 31;  // routing word
  localparam int CRIT_BIT   = 30;  // routing word

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic                 anyRd;   // a read happened, rdData reloads
    logic                 regRd;   // read of a per-source word
    logic                 vpWr;    // control word write
    logic                 dstWr;   // routing word write
    logic                 dstSel;  // per-source access targets routing word
    logic                 iackRd;  // acknowledge read
    logic                 eoiWr;   // end-of-interrupt write
    logic [SRC_IDX_W-1:0] srcIdx;  // addressed source
  } strobe_t;

endpackage

// File: rtl/msi_src_decode.sv
module msi_src_decode #(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 9
) (
  input  logic                  rdEn,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  output msi_src_pkg::strobe_t  strobes
);
  import msi_src_pkg::*;

  localparam int              BANK_BYTES = NUM_SRC * 32;
  localparam logic [ADDR_W-1:0] IACK_OFF = ADDR_W'(BANK_BYTES);
  localparam logic [ADDR_W-1:0] EOI_OFF  = ADDR_W'(BANK_BYTES + 16);

  logic inBank;

  always_comb begin
    inBank          = (addr < IACK_OFF) && (addr[3:0] == 4'd0);
    strobes         = '0;
    strobes.srcIdx  = SRC_IDX_W'(addr >> 5);
    strobes.dstSel  = addr[4];
    strobes.anyRd   = rdEn;
    strobes.regRd   = rdEn && inBank;
    strobes.vpWr    = wrEn && inBank && !addr[4];
    strobes.dstWr   = wrEn && inBank && addr[4];
    strobes.iackRd  = rdEn && (addr == IACK_OFF);
    strobes.eoiWr   = wrEn && (addr == EOI_OFF);
  end

endmodule

// File: rtl/msi_prio_pick.sv
module msi_prio_pick #(
  parameter int N  = 8,
  parameter int PW = 4,
  parameter int IW = 3
) (
  input  logic [N-1:0]         req,
  input  logic [N-1:0][PW-1:0] prio,
  output logic                 found,
  output logic [IW-1:0]        idx,
  output logic [PW-1:0]        topPrio
);
  // Descending scan with >= lets the lowest index win a tie.
  always_comb begin
    found   = 1'b0;
    idx     = '0;
    topPrio = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i] && (!found || prio[i] >= topPrio)) begin
        found   = 1'b1;
        idx     = IW'(i);
        topPrio = prio[i];
      end
    end
  end

endmodule

// File: rtl/msi_src_datapath.sv
module msi_src_datapath #(
  parameter int NUM_SRC = 8,
  parameter int NUM_CPU = 2,
  parameter int PRIO_W  = 4,
  parameter int VEC_W   = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  msi_src_pkg::strobe_t              strobes,
  input  logic [NUM_SRC-1:0]                srcSignal,
  input  logic [msi_src_pkg::DATA_W-1:0]    wrData,
  output logic [msi_src_pkg::DATA_W-1:0]    rdData,
  output logic [NUM_CPU-1:0]                cpuIrq,
  output logic                              extIrq,
  output logic                              critIrq,
  output logic [NUM_SRC-1:0]                pendVec,
  output logic [NUM_SRC-1:0]                isrVec,
  output logic                              ackFound,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]    prioArr
);
  import msi_src_pkg::*;

  localparam int IDX_W = $clog2(NUM_SRC);
  localparam logic [DATA_W-1:0] SPURIOUS = DATA_W'({VEC_W{1'b1}});

  logic [NUM_SRC-1:0]               maskQ, pendQ, isrQ, dstExtQ, dstCritQ;
  logic [NUM_SRC-1:0][PRIO_W-1:0]   prioQ;
  logic [NUM_SRC-1:0][VEC_W-1:0]    vecQ;
  logic [NUM_SRC-1:0][NUM_CPU-1:0]  dstCpuQ;
  logic [DATA_W-1:0]                rdDataQ;

  logic [NUM_SRC-1:0] active, eligible, aboveIns, ackClr, eoiClr;
  logic [IDX_W-1:0]   srcSel, insIdx, ackIdx;
  logic [PRIO_W-1:0]  insPrio, ackPrio;
  logic               insFound;
  logic [DATA_W-1:0]  regVal, rdNext;

  assign srcSel = strobes.srcIdx[IDX_W-1:0];

  // Per-source qualification
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign active[g]   = pendQ[g] | isrQ[g];
    assign eligible[g] = pendQ[g] & ~maskQ[g] & (prioQ[g] != '0);
    assign aboveIns[g] = eligible[g] & (prioQ[g] > insPrio);
  end

  // Current in-service level: highest in-service priority
  msi_prio_pick #(.N(NUM_SRC), .PW(PRIO_W), .IW(IDX_W)) u_insPick (
    .req(isrQ), .prio(prioQ), .found(insFound), .idx(insIdx), .topPrio(insPrio)
  );

  // Acknowledge winner among sources above that level
  msi_prio_pick #(.N(NUM_SRC), .PW(PRIO_W), .IW(IDX_W)) u_ackPick (
    .req(aboveIns), .prio(prioQ), .found(ackFound), .idx(ackIdx), .topPrio(ackPrio)
  );

  assign ackClr = (strobes.iackRd && ackFound) ? (NUM_SRC'(1) << ackIdx) : '0;
  assign eoiClr = (strobes.eoiWr && insFound) ? (NUM_SRC'(1) << insIdx) : '0;

  // Request outputs
  always_comb begin
    cpuIrq  = '0;
    extIrq  = 1'b0;
    critIrq = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eligible[i] && dstExtQ[i]) begin
        extIrq = 1'b1;
      end else if (eligible[i] && dstCritQ[i]) begin
        critIrq = 1'b1;
      end else if (aboveIns[i]) begin
        cpuIrq = cpuIrq | (dstCpuQ[i] & (~dstCpuQ[i] + NUM_CPU'(1)));
      end
    end
  end

  // Read mux
  always_comb begin
    regVal = '0;
    if (strobes.dstSel) begin
      regVal[EXT_BIT]         = dstExtQ[srcSel];
      regVal[CRIT_BIT]        = dstCritQ[srcSel];
      regVal[NUM_CPU-1:0]     = dstCpuQ[srcSel];
    end else begin
      regVal[MASK_BIT]              = maskQ[srcSel];
      regVal[ACT_BIT]               = active[srcSel];
      regVal[PRIO_LSB +: PRIO_W]    = prioQ[srcSel];
      regVal[VEC_W-1:0]             = vecQ[srcSel];
    end
    if (strobes.regRd)       rdNext = regVal;
    else if (strobes.iackRd) rdNext = ackFound ? DATA_W'(vecQ[ackIdx]) : SPURIOUS;
    else                     rdNext = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      maskQ    <= '1;
      prioQ    <= '0;
      vecQ     <= '0;
      dstCpuQ  <= '0;
      dstExtQ  <= '0;
      dstCritQ <= '0;
      pendQ    <= '0;
      isrQ     <= '0;
      rdDataQ  <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (strobes.vpWr && srcSel == IDX_W'(i)) begin
          maskQ[i] <= wrData[MASK_BIT];
          vecQ[i]  <= wrData[VEC_W-1:0];
          if (!active[i]) prioQ[i] <= wrData[PRIO_LSB +: PRIO_W];
        end
        if (strobes.dstWr && srcSel == IDX_W'(i)) begin
          dstExtQ[i]  <= wrData[EXT_BIT];
          dstCritQ[i] <= wrData[CRIT_BIT];
          dstCpuQ[i]  <= wrData[NUM_CPU-1:0];
        end
      end
      pendQ <= (pendQ & ~ackClr) | srcSignal;
      isrQ  <= (isrQ | ackClr) & ~eoiClr;
      if (strobes.anyRd) rdDataQ <= rdNext;
    end
  end

  assign rdData  = rdDataQ;
  assign pendVec = pendQ;
  assign isrVec  = isrQ;
  assign prioArr = prioQ;

endmodule

// File: rtl/msi_src_bank.sv
module msi_src_bank #(
  parameter int NUM_SRC = 8,
  parameter int NUM_CPU = 2,
  parameter int PRIO_W  = 4,
  parameter int VEC_W   = 16,
  parameter int ADDR_W  = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] srcSignal,
  input  logic               rdEn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  output logic [NUM_CPU-1:0] cpuIrq,
  output logic               extIrq,
  output logic               critIrq
);

  msi_src_pkg::strobe_t            strobes;
  logic [NUM_SRC-1:0]              pendVec, isrVec;
  logic                            ackFound;
  logic [NUM_SRC-1:0][PRIO_W-1:0]  prioArr;

  msi_src_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_decode (
    .rdEn(rdEn), .wrEn(wrEn), .addr(addr), .strobes(strobes)
  );

  msi_src_datapath #(
    .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .PRIO_W(PRIO_W), .VEC_W(VEC_W)
  ) u_datapath (
    .clk(clk), .rst(rst), .strobes(strobes), .srcSignal(srcSignal),
    .wrData(wrData), .rdData(rdData), .cpuIrq(cpuIrq), .extIrq(extIrq),
    .critIrq(critIrq), .pendVec(pendVec), .isrVec(isrVec),
    .ackFound(ackFound), .prioArr(prioArr)
  );

endmodule

// File: rtl/msi_src_bank_chk.sv
module msi_src_bank_chk #(
  parameter int NUM_SRC = 8,
  parameter int NUM_CPU = 2,
  parameter int PRIO_W  = 4,
  parameter int VEC_W   = 16
) (
  input logic                             clk,
  input logic                             rst,
  input msi_src_pkg::strobe_t             strobes,
  input logic [31:0]                      rdData,
  input logic [NUM_CPU-1:0]               cpuIrq,
  input logic                             extIrq,
  input logic                             critIrq,
  input logic [NUM_SRC-1:0]               pendVec,
  input logic [NUM_SRC-1:0]               isrVec,
  input logic                             ackFound,
  input logic [NUM_SRC-1:0][PRIO_W-1:0]   prioArr
);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cpuIrq == '0 && !extIrq && !critIrq && pendVec == '0 && isrVec == '0));

  p_irq_needs_pending_r10: assert property (@(posedge clk) disable iff (rst)
    (|cpuIrq || extIrq || critIrq) |-> (|pendVec));

  p_spurious_r8: assert property (@(posedge clk) disable iff (rst)
    (strobes.iackRd && !ackFound && !strobes.eoiWr) |=>
      (rdData == 32'({VEC_W{1'b1}}) && isrVec == $past(isrVec)));

  p_ack_enters_service_r8: assert property (@(posedge clk) disable iff (rst)
    (strobes.iackRd && ackFound && !strobes.eoiWr) |=>
      ($countones(isrVec) == $countones($past(isrVec)) + 1));

  p_eoi_retires_one_r9: assert property (@(posedge clk) disable iff (rst)
    (strobes.eoiWr && !strobes.iackRd && (|isrVec)) |=>
      ($countones(isrVec) + 1 == $countones($past(isrVec))));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_frozen
    p_prio_frozen_r6: assert property (@(posedge clk) disable iff (rst)
      (pendVec[g] || isrVec[g]) |=> $stable(prioArr[g]));
  end

endmodule

bind msi_src_bank msi_src_bank_chk #(
  .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .PRIO_W(PRIO_W), .VEC_W(VEC_W)
) u_chk (
  .clk(clk), .rst(rst), .strobes(strobes), .rdData(rdData), .cpuIrq(cpuIrq),
  .extIrq(extIrq), .critIrq(critIrq), .pendVec(pendVec), .isrVec(isrVec),
  .ackFound(ackFound), .prioArr(prioArr)
);

// File: tb/msi_src_bank_tb.sv
`timescale 1ns/1ps
module msi_src_bank_tb;
  localparam int NS = 8;
  localparam int NC = 2;
  localparam logic [8:0] IACK = 9'h100;
  localparam logic [8:0] EOI  = 9'h110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0] srcSignal = '0;
  logic rdEn = 1'b0, wrEn = 1'b0;
  logic [8:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [NC-1:0] cpuIrq;
  logic extIrq, critIrq;

  always #2.5 clk = ~clk;

  msi_src_bank u_dut (
    .clk(clk), .rst(rst), .srcSignal(srcSignal), .rdEn(rdEn), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .cpuIrq(cpuIrq),
    .extIrq(extIrq), .critIrq(critIrq)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;

  // Reference model state
  bit          mMask[NS];
  int          mPrio[NS];
  int          mVec[NS];
  logic [31:0] mDst[NS];
  bit          mPend[NS];
  bit          mIsr[NS];
  logic [31:0] expRd;
  bit          chkRd = 0;
  string       rdTag = "R2";

  function automatic bit elig(int i);
    return mPend[i] && !mMask[i] && mPrio[i] != 0;
  endfunction

  function automatic int insLevel();
    int p = 0;
    for (int i = 0; i < NS; i++) if (mIsr[i] && mPrio[i] > p) p = mPrio[i];
    return p;
  endfunction

  function automatic int winner();
    int best = -1;
    int lvl = insLevel();
    for (int i = 0; i < NS; i++)
      if (elig(i) && mPrio[i] > lvl && (best < 0 || mPrio[i] > mPrio[best])) best = i;
    return best;
  endfunction

  function automatic int retireTarget();
    int best = -1;
    for (int i = 0; i < NS; i++)
      if (mIsr[i] && (best < 0 || mPrio[i] > mPrio[best])) best = i;
    return best;
  endfunction

  function automatic logic [NC+1:0] expOutputs();
    logic [NC-1:0] c = '0;
    logic x = 0, k = 0;
    int lvl = insLevel();
    for (int i = 0; i < NS; i++) begin
      if (elig(i)) begin
        if (mDst[i][31]) x = 1;
        else if (mDst[i][30]) k = 1;
        else if (mPrio[i] > lvl) begin
          for (int j = 0; j < NC; j++)
            if (mDst[i][j]) begin c[j] = 1; break; end
        end
      end
    end
    return {c, x, k};
  endfunction

  // Model update at each active edge
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NS; i++) begin
        mMask[i] = 1; mPrio[i] = 0; mVec[i] = 0; mDst[i] = 0; mPend[i] = 0; mIsr[i] = 0;
      end
      chkRd = 0;
    end else begin
      int w, e, n;
      bit act;
      w = winner();
      e = retireTarget();
      n = int'(addr >> 5);
      act = (n < NS) ? (mPend[n] | mIsr[n]) : 0;
      if (rdEn) begin
        expRd = 0;
        if (addr < 9'h100 && addr[3:0] == 0) begin
          if (addr[4]) expRd = mDst[n];
          else begin
            expRd[31] = mMask[n]; expRd[30] = act;
            expRd[19:16] = 4'(mPrio[n]); expRd[15:0] = 16'(mVec[n]);
          end
        end else if (addr == IACK) expRd = (w >= 0) ? 32'(mVec[w]) : 32'h0000_FFFF;
        chkRd = 1;
        if (addr == IACK && w >= 0) begin mPend[w] = 0; mIsr[w] = 1; end
      end
      if (wrEn) begin
        if (addr == EOI && e >= 0) mIsr[e] = 0;
        if (addr < 9'h100 && addr[3:0] == 0) begin
          if (addr[4]) mDst[n] = wrData & 32'hC000_0003;
          else begin
            mMask[n] = wrData[31];
            mVec[n]  = int'(wrData[15:0]);
            if (!act) mPrio[n] = int'(wrData[19:16]);
          end
        end
      end
      for (int i = 0; i < NS; i++) if (srcSignal[i]) mPend[i] = 1;
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      logic [NC+1:0] ex;
      ex = expOutputs();
      checks++;
      if ({cpuIrq, extIrq, critIrq} !== ex) begin
        fails++;
        $display("FAIL R10 R7 outputs {cpu,ext,crit} actual=%b expected=%b at cycle %0d",
                 {cpuIrq, extIrq, critIrq}, ex, cycles);
      end
      if (chkRd) begin
        checks++;
        if (rdData !== expRd) begin
          fails++;
          $display("FAIL %s read data actual=%h expected=%h", rdTag, rdData, expRd);
        end
        chkRd = 0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    wrEn = 1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic rd(input logic [8:0] a, input string tag);
    rdTag = tag; rdEn = 1; addr = a;
    @(negedge clk);
    rdEn = 0;
  endtask

  task automatic rdConst(input logic [8:0] a, input logic [31:0] exp, input string tag);
    rd(a, tag);
    check(rdData === exp, tag, rdData, exp);
  endtask

  task automatic pulse(input logic [NS-1:0] m);
    srcSignal = m;
    @(negedge clk);
    srcSignal = '0;
  endtask

  function automatic logic [8:0] vp(int n); return 9'(n * 32); endfunction
  function automatic logic [8:0] ds(int n); return 9'(n * 32 + 16); endfunction

  task automatic summary();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check({cpuIrq, extIrq, critIrq} === '0, "R1 outputs", 32'({cpuIrq, extIrq, critIrq}), 0);
    rdConst(vp(0), 32'h8000_0000, "R1");
    rdConst(ds(3), 32'h0000_0000, "R1");
    // R2: field layout, reserved bits read 0
    wr(vp(2), 32'h7FFF_1234);
    rdConst(vp(2), 32'h000F_1234, "R2");
    wr(ds(2), 32'hFFFF_FFFF);
    rdConst(ds(2), 32'hC000_0003, "R2 R7");
    wr(ds(2), 32'h0000_0001);
    // R3: masked pending source stays quiet
    wr(vp(1), 32'h8005_0011);
    wr(ds(1), 32'h0000_0002);
    pulse(8'h02);
    check(cpuIrq === 2'b00, "R3 masked", 32'(cpuIrq), 0);
    rdConst(vp(1), 32'hC005_0011, "R5");
    wr(vp(1), 32'h0005_0011);
    check(cpuIrq === 2'b10, "R3 unmask", 32'(cpuIrq), 2);
    // R4: zero priority
    wr(ds(3), 32'h0000_0001);
    wr(vp(3), 32'h0000_0033);
    pulse(8'h08);
    check(cpuIrq[0] === 1'b0, "R4", 32'(cpuIrq), 2);
    // R6: priority frozen while active, vector still written
    wr(vp(1), 32'h0009_0022);
    rdConst(vp(1), 32'h4005_0022, "R6");
    // R8: acknowledge
    rdConst(IACK, 32'h0000_0022, "R8");
    check(cpuIrq === 2'b00, "R10 in service", 32'(cpuIrq), 0);
    wr(vp(4), 32'h0005_0044);
    wr(ds(4), 32'h0000_0001);
    pulse(8'h14);
    check(cpuIrq === 2'b01, "R10 above level", 32'(cpuIrq), 1);
    rdConst(IACK, 32'h0000_1234, "R8 nested");
    rdConst(IACK, 32'h0000_FFFF, "R8 spurious");
    // R9: retire most recent
    wr(EOI, 32'h0);
    check(cpuIrq === 2'b00, "R9 equal not above", 32'(cpuIrq), 0);
    wr(EOI, 32'h0);
    check(cpuIrq === 2'b01, "R9 level drops", 32'(cpuIrq), 1);
    rdConst(IACK, 32'h0000_0044, "R8");
    wr(EOI, 32'h0);
    // R8: tie goes to lowest index
    wr(vp(5), 32'h0007_0055); wr(ds(5), 32'h0000_0001);
    wr(vp(6), 32'h0007_0066); wr(ds(6), 32'h0000_0001);
    pulse(8'h60);
    rdConst(IACK, 32'h0000_0055, "R8 tie");
    wr(EOI, 32'h0);
    rdConst(IACK, 32'h0000_0066, "R8 tie");
    wr(EOI, 32'h0);
    wr(EOI, 32'h0);  // nothing in service (R9)
    // R7: routing precedence
    wr(ds(7), 32'hC000_0001);
    wr(vp(7), 32'h0003_0077);
    pulse(8'h80);
    check({cpuIrq, extIrq, critIrq} === 4'b0010, "R7 ext", 32'({cpuIrq, extIrq, critIrq}), 2);
    wr(ds(7), 32'h4000_0001);
    check({cpuIrq, extIrq, critIrq} === 4'b0001, "R7 crit", 32'({cpuIrq, extIrq, critIrq}), 1);
    wr(ds(7), 32'h0000_0003);
    check({cpuIrq, extIrq, critIrq} === 4'b0100, "R7 lowest cpu", 32'({cpuIrq, extIrq, critIrq}), 4);
    rdConst(IACK, 32'h0000_0077, "R8");
    wr(EOI, 32'h0);
    // R11: unmapped addresses
    wr(9'h104, 32'hFFFF_FFFF);
    rdConst(9'h104, 32'h0, "R11");
    rdConst(vp(2) + 9'd4, 32'h0, "R11");
    rdConst(vp(2), 32'h000F_1234, "R11 untouched");
    // R3: masked pending not acknowledged, then unmasked
    wr(vp(0), 32'h8002_00AA);
    wr(ds(0), 32'h0000_0001);
    pulse(8'h01);
    rdConst(IACK, 32'h0000_FFFF, "R3 masked ack");
    wr(vp(0), 32'h0002_00AA);
    rdConst(IACK, 32'h0000_00AA, "R3 unmasked ack");
    wr(EOI, 32'h0);
    // Mixed traffic against the model
    for (int it = 0; it < 600; it++) begin
      int op, n;
      op = int'($urandom_range(0, 6));
      n  = int'($urandom_range(0, NS - 1));
      srcSignal = ($urandom_range(0, 3) == 0) ? NS'($urandom) : '0;
      case (op)
        0: wr(vp(n), $urandom);
        1: wr(ds(n), $urandom);
        2: rd(IACK, "R8 mixed");
        3: wr(EOI, 32'h0);
        4: rd(($urandom_range(0, 1) == 0) ? vp(n) : ds(n), "R2 R5 mixed");
        5: rd(9'($urandom), "R11 mixed");
        default: @(negedge clk);
      endcase
      srcSignal = '0;
    end
    repeat (2) @(negedge clk);
    summary();
  end

endmodule